// File: doc/BRIEF.md
# SCSI Controller Register Front End

This block is the byte-wide register face of a SCSI protocol controller. A simple register bus (4-bit address, read strobe, write strobe, 8-bit data in and out) reaches a read bank and a write bank that share each address. The block holds the status, interrupt, sequence-step, FIFO-flags, configuration and command registers, a 24-bit transfer counter, a 16-byte data FIFO and a command-byte FIFO. It drives a level interrupt output.

Housekeeping commands are decoded here: no-op, FIFO flush, chip reset, bus reset, message accepted, and enable or disable selection. All other command codes are passed on as a one-cycle strobe to the phase sequencer. That sequencer lives outside the block and sets status and interrupt bits through set inputs, loads the phase field and sequence step, and counts transferred bytes down. The command FIFO sits between the transfer engine and the sequencer. Both of its sides are valid/ready streams. A byte moves on a clock edge where valid and ready are both high. `cmd_in_ready` is low while the FIFO is full. `cmd_out_valid` stays high and `cmd_out_data` holds still until `cmd_out_ready` takes the byte.

Read data is combinational while `reg_rd` is high. A read's side effect (popping a FIFO, clearing the interrupt register) and a write's effect take place on the rising clock edge that ends the access.

Top module: `scsi_regfront`

## Requirements
- R1: After reset the following all read 0:
  - status (address 4)
  - interrupt (address 5)
  - sequence step (address 6)
  - FIFO flags (address 7)
  - transfer count low (address 0)

  Configuration 1 (address 8) reads 7, `irq_o` is low and `cmd_out_valid` is low.
- R2: `irq_o` equals the interrupt-pending bit (status bit 7). It rises only when that bit goes from 0 to 1. A further raise while it is already set leaves `irq_o` high without a new edge.
- R3: A read of address 5 returns the interrupt register. On the same edge it clears that register, status bit 4 (terminal count) and the pending bit, so `irq_o` falls.
- R4: The sequence step (address 6, bits 2:0) is unchanged by a read of the interrupt register. Only `seq_load` or the message-accepted command changes it.
- R5: Address 7 returns the data FIFO's byte count in bits 4:0. Bits 7:5 read as 0.
- R6: Until address 14 has been written, a read of address 14 returns the constant `CHIP_ID`. After the first write it returns bits 23:16 of the transfer counter.
- R7: A write to address 2 pushes into the data FIFO. A push into a full FIFO (16 bytes) is dropped and sets status bit 6 (overrun). Reads of address 2 pop bytes in order. A read of an empty FIFO returns 0x00 and changes nothing.
- R8: Command 0x03 (bus reset) sets interrupt bit 7 and raises the pending bit, unless configuration 1 bit 6 is set, in which case nothing changes.
- R9: Command 0x01 empties the data FIFO. Commands 0x44 and 0x45 both clear the interrupt register.
- R10: Command 0x12 (message accepted) sets interrupt bit 5, raises the pending bit and clears the sequence step.
- R11: Command 0x02 (chip reset) returns every register, both FIFOs and the chip-ID latch to the reset state.
- R12: Any command byte with bit 7 set reloads the transfer counter from the start count written at addresses 0, 1 and 14. A start count of 0 loads 0x10000. Each `tc_dec` pulse decrements a non-zero counter. The step that reaches 0 sets status bit 4.
- R13: Command codes other than 0x00, 0x01, 0x02, 0x03, 0x12, 0x44 and 0x45 (bit 7 ignored) give a one-cycle `cmd_strobe` with the command byte on `cmd_code`. Housekeeping codes give none.
- R14: The command FIFO accepts a byte when `cmd_in_valid` and `cmd_in_ready` are high. It presents bytes in arrival order and holds the head byte while `cmd_out_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid while reg_rd is high |
| irq_o | output | 1 | Level interrupt |
| stat_set | input | 7 | OR-set of status bits 6:0 |
| stat_load | input | 1 | Load status bits 6:0 from stat_val |
| stat_val | input | 7 | Status value for stat_load |
| intr_set | input | 8 | OR-set of interrupt register bits |
| irq_raise | input | 1 | Raise the interrupt-pending bit |
| seq_load | input | 1 | Load the sequence step |
| seq_val | input | 3 | Sequence step value |
| tc_dec | input | 1 | Decrement the transfer counter |
| sel_target | output | 3 | Target ID written at address 4 |
| cmd_strobe | output | 1 | Forwarded-command pulse |
| cmd_code | output | 8 | Forwarded command byte |
| cmd_in_valid | input | 1 | Command FIFO input valid |
| cmd_in_ready | output | 1 | Command FIFO input ready |
| cmd_in_data | input | 8 | Command FIFO input byte |
| cmd_out_valid | output | 1 | Command FIFO output valid |
| cmd_out_ready | input | 1 | Command FIFO output ready |
| cmd_out_data | output | 8 | Command FIFO head byte |

## Verification
The assertions take for granted that `reg_rd` and `reg_wr` are never high in the same cycle. The interrupt-clear property further assumes that the sequencer does not set interrupt bits in the cycle of an interrupt-register read. The stimulus keeps to both rules: every register access goes through a task that raises exactly one strobe for one cycle, and the set inputs are pulsed only between accesses. The random phases drive either register traffic or the command-FIFO streams, never both at once.

// File: rtl/srf_pkg.sv
package srf_pkg;
  localparam int TC_W = 24;

  localparam logic [3:0] A_TC_LO  = 4'd0;
  localparam logic [3:0] A_TC_MID = 4'd1;
  localparam logic [3:0] A_FIFO   = 4'd2;
  localparam logic [3:0] A_CMD    = 4'd3;
  localparam logic [3:0] A_STAT   = 4'd4;
  localparam logic [3:0] A_INTR   = 4'd5;
  localparam logic [3:0] A_SEQ    = 4'd6;
  localparam logic [3:0] A_FLAGS  = 4'd7;
  localparam logic [3:0] A_CFG1   = 4'd8;
  localparam logic [3:0] A_CFG2   = 4'd11;
  localparam logic [3:0] A_CFG3   = 4'd12;
  localparam logic [3:0] A_TC_HI  = 4'd14;

  localparam int ST_ERR = 6;
  localparam int ST_TC  = 4;
  localparam int IN_RST  = 7;
  localparam int IN_DISC = 5;
  localparam int CFG1_NORPT = 6;
  localparam logic [7:0] CFG1_RESET = 8'h07;

  localparam logic [6:0] OP_NOP     = 7'h00;
  localparam logic [6:0] OP_FLUSH   = 7'h01;
  localparam logic [6:0] OP_CHIPRST = 7'h02;
  localparam logic [6:0] OP_BUSRST  = 7'h03;
  localparam logic [6:0] OP_MSGOK   = 7'h12;
  localparam logic [6:0] OP_SELEN   = 7'h44;
  localparam logic [6:0] OP_SELDIS  = 7'h45;

  typedef struct packed {
    logic flush;
    logic chip_rst;
    logic bus_rst;
    logic msg_ok;
    logic sel_clr;
    logic forward;
  } cmd_dec_t;
endpackage

// File: rtl/srf_fifo.sv
module srf_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic             full,
  output logic             empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH-1);
  localparam logic [CW-1:0] CAP  = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic do_push, do_pop;

  assign full    = (count == CAP);
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else if (clr) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
      if (do_push && !do_pop)      count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wptr] <= din;
  end

  p_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CAP);
  p_full_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !clr) |=> (count == CAP));
  p_empty_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push && !clr) |=> (count == '0));
endmodule

// File: rtl/srf_cmd_decode.sv
module srf_cmd_decode
  import srf_pkg::*;
(
  input  logic [6:0] op,
  output cmd_dec_t   dec
);
  always_comb begin
    dec = '0;
    unique case (op)
      OP_NOP:               ;
      OP_FLUSH:             dec.flush    = 1'b1;
      OP_CHIPRST:           dec.chip_rst = 1'b1;
      OP_BUSRST:            dec.bus_rst  = 1'b1;
      OP_MSGOK:             dec.msg_ok   = 1'b1;
      OP_SELEN, OP_SELDIS:  dec.sel_clr  = 1'b1;
      default:              dec.forward  = 1'b1;
    endcase
  end
endmodule

// File: rtl/srf_tc.sv
module srf_tc #(
  parameter int W = 24,
  parameter int ZERO_RELOAD_LOG2 = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] start,
  input  logic         dec,
  output logic [W-1:0] count,
  output logic         zero_hit
);
  localparam logic [W-1:0] RELOAD = W'(1) << ZERO_RELOAD_LOG2;
  localparam logic [W-1:0] ONE    = W'(1);

  assign zero_hit = dec && !load && !clr && (count == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       count <= '0;
    else if (clr)                     count <= '0;
    else if (load)                    count <= (start == '0) ? RELOAD : start;
    else if (dec && count != '0)      count <= count - 1'b1;
  end

  p_reload_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clr) |=> (count == (($past(start) == '0) ? RELOAD : $past(start))));
  p_no_wrap_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && !load) |=> (count == '0));
endmodule

// File: rtl/scsi_regfront.sv
module scsi_regfront
  import srf_pkg::*;
#(
  parameter int         DATA_DEPTH = 16,
  parameter int         CMD_DEPTH  = 32,
  parameter logic [7:0] CHIP_ID    = 8'hA2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] reg_addr,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq_o,
  input  logic [6:0] stat_set,
  input  logic       stat_load,
  input  logic [6:0] stat_val,
  input  logic [7:0] intr_set,
  input  logic       irq_raise,
  input  logic       seq_load,
  input  logic [2:0] seq_val,
  input  logic       tc_dec,
  output logic [2:0] sel_target,
  output logic       cmd_strobe,
  output logic [7:0] cmd_code,
  input  logic       cmd_in_valid,
  output logic       cmd_in_ready,
  input  logic [7:0] cmd_in_data,
  output logic       cmd_out_valid,
  input  logic       cmd_out_ready,
  output logic [7:0] cmd_out_data
);
  localparam int DCW = $clog2(DATA_DEPTH+1);
  localparam int CCW = $clog2(CMD_DEPTH+1);

  // register bus decode
  logic wr_cmd, wr_fifo, rd_fifo, rd_intr;
  cmd_dec_t dec;
  logic srst, bus_rst_rep, raise_any;

  assign wr_cmd  = reg_wr && (reg_addr == A_CMD);
  assign wr_fifo = reg_wr && (reg_addr == A_FIFO);
  assign rd_fifo = reg_rd && (reg_addr == A_FIFO);
  assign rd_intr = reg_rd && (reg_addr == A_INTR);

  srf_cmd_decode u_dec (.op(reg_wdata[6:0]), .dec(dec));

  assign srst        = wr_cmd && dec.chip_rst;
  assign bus_rst_rep = wr_cmd && dec.bus_rst;
  assign raise_any   = irq_raise
                     || (bus_rst_rep && !cfg1_q[CFG1_NORPT])
                     || (wr_cmd && dec.msg_ok);

  // state
  logic [6:0]      stat_q, stat_d;
  logic            pend_q, pend_d;
  logic [7:0]      intr_q, intr_d;
  logic [2:0]      seq_q, seq_d;
  logic [7:0]      cfg1_q, cfg1_d, cfg2_q, cfg2_d, cfg3_q, cfg3_d;
  logic [7:0]      cmd_q, cmd_d;
  logic [TC_W-1:0] tcs_q, tcs_d;
  logic            tchi_wr_q, tchi_wr_d;
  logic [2:0]      tgt_q, tgt_d;
  logic            strobe_q, strobe_d;
  logic [7:0]      code_q, code_d;

  // data FIFO
  logic [7:0]     d_dout;
  logic [DCW-1:0] d_count;
  logic           d_full, d_empty;

  srf_fifo #(.WIDTH(8), .DEPTH(DATA_DEPTH)) u_dfifo (
    .clk(clk), .rst_n(rst_n),
    .clr(srst || (wr_cmd && dec.flush)),
    .push(wr_fifo), .din(reg_wdata),
    .pop(rd_fifo), .dout(d_dout),
    .count(d_count), .full(d_full), .empty(d_empty)
  );

  // command FIFO with stream ports
  logic [CCW-1:0] c_count;
  logic           c_full, c_empty;

  srf_fifo #(.WIDTH(8), .DEPTH(CMD_DEPTH)) u_cfifo (
    .clk(clk), .rst_n(rst_n), .clr(srst),
    .push(cmd_in_valid), .din(cmd_in_data),
    .pop(cmd_out_ready), .dout(cmd_out_data),
    .count(c_count), .full(c_full), .empty(c_empty)
  );

  assign cmd_in_ready  = !c_full;
  assign cmd_out_valid = !c_empty;

  // transfer counter
  logic [TC_W-1:0] tc_cnt;
  logic            tc_zero;

  srf_tc #(.W(TC_W), .ZERO_RELOAD_LOG2(16)) u_tc (
    .clk(clk), .rst_n(rst_n), .clr(srst),
    .load(wr_cmd && reg_wdata[7] && !srst),
    .start(tcs_q), .dec(tc_dec),
    .count(tc_cnt), .zero_hit(tc_zero)
  );

  // next state
  always_comb begin
    stat_d    = stat_q;
    pend_d    = pend_q;
    intr_d    = intr_q;
    seq_d     = seq_q;
    cfg1_d    = cfg1_q;
    cfg2_d    = cfg2_q;
    cfg3_d    = cfg3_q;
    cmd_d     = cmd_q;
    tcs_d     = tcs_q;
    tchi_wr_d = tchi_wr_q;
    tgt_d     = tgt_q;
    strobe_d  = 1'b0;
    code_d    = code_q;

    if (stat_load) stat_d = stat_val;
    if (seq_load)  seq_d  = seq_val;

    if (rd_intr) begin
      intr_d        = '0;
      stat_d[ST_TC] = 1'b0;
      pend_d        = 1'b0;
    end

    if (reg_wr) begin
      unique case (reg_addr)
        A_TC_LO:  tcs_d[7:0]   = reg_wdata;
        A_TC_MID: tcs_d[15:8]  = reg_wdata;
        A_TC_HI: begin
          tcs_d[23:16] = reg_wdata;
          tchi_wr_d    = 1'b1;
        end
        A_CMD:    cmd_d  = reg_wdata;
        A_STAT:   tgt_d  = reg_wdata[2:0];
        A_CFG1:   cfg1_d = reg_wdata;
        A_CFG2:   cfg2_d = reg_wdata;
        A_CFG3:   cfg3_d = reg_wdata;
        default:  ;
      endcase
    end

    if (wr_cmd) begin
      if (dec.sel_clr) intr_d = '0;
      if (bus_rst_rep && !cfg1_q[CFG1_NORPT]) intr_d[IN_RST] = 1'b1;
      if (dec.msg_ok) begin
        intr_d[IN_DISC] = 1'b1;
        seq_d           = '0;
      end
      strobe_d = dec.forward;
      if (dec.forward) code_d = reg_wdata;
    end

    stat_d = stat_d | stat_set;
    intr_d = intr_d | intr_set;
    if (tc_zero)           stat_d[ST_TC]  = 1'b1;
    if (wr_fifo && d_full) stat_d[ST_ERR] = 1'b1;
    if (raise_any)         pend_d = 1'b1;

    if (srst) begin
      stat_d    = '0;
      pend_d    = 1'b0;
      intr_d    = '0;
      seq_d     = '0;
      cfg1_d    = CFG1_RESET;
      cfg2_d    = '0;
      cfg3_d    = '0;
      cmd_d     = '0;
      tcs_d     = '0;
      tchi_wr_d = 1'b0;
      tgt_d     = '0;
      strobe_d  = 1'b0;
      code_d    = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q    <= '0;
      pend_q    <= 1'b0;
      intr_q    <= '0;
      seq_q     <= '0;
      cfg1_q    <= CFG1_RESET;
      cfg2_q    <= '0;
      cfg3_q    <= '0;
      cmd_q     <= '0;
      tcs_q     <= '0;
      tchi_wr_q <= 1'b0;
      tgt_q     <= '0;
      strobe_q  <= 1'b0;
      code_q    <= '0;
    end else begin
      stat_q    <= stat_d;
      pend_q    <= pend_d;
      intr_q    <= intr_d;
      seq_q     <= seq_d;
      cfg1_q    <= cfg1_d;
      cfg2_q    <= cfg2_d;
      cfg3_q    <= cfg3_d;
      cmd_q     <= cmd_d;
      tcs_q     <= tcs_d;
      tchi_wr_q <= tchi_wr_d;
      tgt_q     <= tgt_d;
      strobe_q  <= strobe_d;
      code_q    <= code_d;
    end
  end

  assign irq_o      = pend_q;
  assign sel_target = tgt_q;
  assign cmd_strobe = strobe_q;
  assign cmd_code   = code_q;

  // read bank
  logic [7:0] flags;
  assign flags = 8'(d_count) & 8'h1F;

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      unique case (reg_addr)
        A_TC_LO:  reg_rdata = tc_cnt[7:0];
        A_TC_MID: reg_rdata = tc_cnt[15:8];
        A_TC_HI:  reg_rdata = tchi_wr_q ? tc_cnt[23:16] : CHIP_ID;
        A_FIFO:   reg_rdata = d_empty ? 8'h00 : d_dout;
        A_CMD:    reg_rdata = cmd_q;
        A_STAT:   reg_rdata = {pend_q, stat_q};
        A_INTR:   reg_rdata = intr_q;
        A_SEQ:    reg_rdata = {5'b0, seq_q};
        A_FLAGS:  reg_rdata = flags;
        A_CFG1:   reg_rdata = cfg1_q;
        A_CFG2:   reg_rdata = cfg2_q;
        A_CFG3:   reg_rdata = cfg3_q;
        default:  reg_rdata = '0;
      endcase
    end
  end

  // checks on the block's own behaviour
  p_one_access_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd && reg_wr));
  p_irq_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(raise_any));
  p_irq_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !rd_intr && !srst) |=> irq_o);
  p_intr_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_intr && intr_set == '0 && !irq_raise) |=> (intr_q == '0 && !irq_o));
  p_seq_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_load && !wr_cmd) |=> $stable(seq_q));
  p_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_FLAGS) |-> (reg_rdata[7:5] == 3'b000));
  p_strobe_r13: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_strobe |-> $past(wr_cmd));
endmodule

// File: tb/scsi_regfront_test.sv
module scsi_regfront_test;
  localparam int CLK_PERIOD = 10;
  localparam int DDEPTH = 16;
  localparam int CDEPTH = 32;
  localparam logic [7:0] ID = 8'hA2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic irq_o;
  logic [6:0] stat_set = '0;
  logic stat_load = 1'b0;
  logic [6:0] stat_val = '0;
  logic [7:0] intr_set = '0;
  logic irq_raise = 1'b0;
  logic seq_load = 1'b0;
  logic [2:0] seq_val = '0;
  logic tc_dec = 1'b0;
  logic [2:0] sel_target;
  logic cmd_strobe;
  logic [7:0] cmd_code;
  logic cmd_in_valid = 1'b0;
  logic cmd_in_ready;
  logic [7:0] cmd_in_data = '0;
  logic cmd_out_valid;
  logic cmd_out_ready = 1'b0;
  logic [7:0] cmd_out_data;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scsi_regfront uut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_flags(input int n);
    return 8'(n) & 8'h1F;
  endfunction

  function automatic logic [23:0] exp_reload(input logic [23:0] s);
    return (s == 0) ? 24'h010000 : s;
  endfunction

  // tasks are entered and left at a falling edge
  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic pulse_dec();
    tc_dec = 1'b1; @(negedge clk); tc_dec = 1'b0;
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic [7:0] v;
    logic [7:0] q[$];
    logic [7:0] cq[$];
    logic [7:0] im;
    logic ovr;
    void'($urandom(32'h5C51));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(4'd4, v); check("R1 status", v, 8'h00);
    rd(4'd5, v); check("R1 intr", v, 8'h00);
    rd(4'd6, v); check("R1 seq", v, 8'h00);
    rd(4'd7, v); check("R1 flags", v, 8'h00);
    rd(4'd8, v); check("R1 cfg1", v, 8'h07);
    rd(4'd0, v); check("R1 tc lo", v, 8'h00);
    check("R1 irq", irq_o, 0);
    check("R1 cout_valid", cmd_out_valid, 0);

    // R6 chip id latch
    rd(4'd14, v); check("R6 id", v, ID);
    rd(4'd14, v); check("R6 id again", v, ID);
    wr(4'd14, 8'h00);
    rd(4'd14, v); check("R6 after write", v, 8'h00);

    // R12 transfer counter
    wr(4'd0, 8'h03);
    wr(4'd3, 8'h80);
    check("R12 no strobe for dma nop", cmd_strobe, 0);
    rd(4'd0, v); check("R12 reload", v, exp_reload(24'd3) & 8'hFF);
    pulse_dec(); pulse_dec();
    rd(4'd0, v); check("R12 dec", v, 8'h01);
    rd(4'd4, v); check("R12 tc bit before zero", v[4], 0);
    pulse_dec();
    rd(4'd4, v); check("R12 tc bit at zero", v[4], 1);
    pulse_dec();
    rd(4'd0, v); check("R12 hold at zero", v, 8'h00);
    wr(4'd0, 8'h00);
    wr(4'd3, 8'h81);
    rd(4'd14, v); check("R12 zero reload hi", v, exp_reload(24'd0) >> 16);
    rd(4'd1, v); check("R12 zero reload mid", v, 8'h00);
    wr(4'd14, 8'h3C); wr(4'd0, 8'h05); wr(4'd3, 8'h80);
    rd(4'd14, v); check("R6 counter high byte", v, 8'h3C);

    // R2/R3 interrupt pending
    intr_set = 8'h18; irq_raise = 1'b1; @(negedge clk);
    intr_set = '0; irq_raise = 1'b0;
    check("R2 irq rises", irq_o, 1);
    irq_raise = 1'b1; @(negedge clk); irq_raise = 1'b0;
    check("R2 irq stays high", irq_o, 1);
    rd(4'd4, v); check("R2 pending bit", v[7], 1);
    seq_val = 3'd5; seq_load = 1'b1; @(negedge clk); seq_load = 1'b0;
    rd(4'd5, v); check("R3 intr value", v, 8'h18);
    check("R3 irq cleared", irq_o, 0);
    rd(4'd5, v); check("R3 intr cleared", v, 8'h00);
    rd(4'd4, v); check("R3 tc bit cleared", v, 8'h00);
    rd(4'd6, v); check("R4 seq kept", v, 8'h05);

    // R10 message accepted
    wr(4'd3, 8'h12);
    check("R10 irq", irq_o, 1);
    check("R13 housekeeping no strobe", cmd_strobe, 0);
    rd(4'd6, v); check("R10 seq cleared", v, 8'h00);
    rd(4'd5, v); check("R10 intr", v, 8'h20);

    // R8 bus reset
    wr(4'd3, 8'h03);
    check("R8 irq", irq_o, 1);
    rd(4'd5, v); check("R8 intr", v, 8'h80);
    wr(4'd8, 8'h47);
    wr(4'd3, 8'h03);
    check("R8 suppressed irq", irq_o, 0);
    rd(4'd5, v); check("R8 suppressed intr", v, 8'h00);
    rd(4'd8, v); check("R8 cfg1", v, 8'h47);

    // R9 flush and selection commands
    wr(4'd2, 8'h11); wr(4'd2, 8'h22); wr(4'd2, 8'h33);
    rd(4'd7, v); check("R5 flags 3", v, exp_flags(3));
    wr(4'd3, 8'h01);
    rd(4'd7, v); check("R9 flushed", v, exp_flags(0));
    intr_set = 8'h08; @(negedge clk); intr_set = '0;
    wr(4'd3, 8'h44);
    rd(4'd5, v); check("R9 select enable clears", v, 8'h00);
    intr_set = 8'h41; @(negedge clk); intr_set = '0;
    wr(4'd3, 8'h45);
    rd(4'd5, v); check("R9 select disable clears", v, 8'h00);

    // R13 forwarded command
    wr(4'd3, 8'hC1);
    check("R13 strobe", cmd_strobe, 1);
    check("R13 code", cmd_code, 8'hC1);
    @(negedge clk);
    check("R13 strobe one cycle", cmd_strobe, 0);

    // R7 directed full and empty
    for (int i = 0; i < DDEPTH + 1; i++) wr(4'd2, 8'(i + 1));
    rd(4'd7, v); check("R5 flags full", v, exp_flags(DDEPTH));
    rd(4'd4, v); check("R7 overrun bit", v[6], 1);
    for (int i = 0; i < DDEPTH; i++) begin
      rd(4'd2, v); check("R7 order", v, 8'(i + 1));
    end
    rd(4'd2, v); check("R7 empty read", v, 8'h00);
    rd(4'd7, v); check("R7 empty unchanged", v, exp_flags(0));

    // R7/R5 random data FIFO traffic
    stat_val = '0; stat_load = 1'b1; @(negedge clk); stat_load = 1'b0;
    ovr = 1'b0;
    for (int i = 0; i < 400; i++) begin
      if ($urandom % 5 < 3) begin
        v = 8'($urandom);
        if (q.size() < DDEPTH) q.push_back(v); else ovr = 1'b1;
        wr(4'd2, v);
      end else begin
        logic [7:0] e;
        e = (q.size() > 0) ? q.pop_front() : 8'h00;
        rd(4'd2, v); check("R7 random pop", v, e);
      end
      if (i % 16 == 0) begin
        rd(4'd7, v); check("R5 random flags", v, exp_flags(q.size()));
      end
    end
    rd(4'd4, v); check("R7 random overrun", v[6], ovr);

    // R3 random interrupt accumulation
    im = '0;
    for (int i = 0; i < 120; i++) begin
      if ($urandom % 4 != 0) begin
        logic [7:0] s;
        s = 8'($urandom);
        intr_set = s; @(negedge clk); intr_set = '0;
        im = im | s;
      end else begin
        rd(4'd5, v); check("R3 random read", v, im);
        im = '0;
      end
    end

    // R14 random command FIFO streams
    for (int i = 0; i < 600; i++) begin
      cmd_in_valid = ($urandom % 3 != 0);
      cmd_in_data = 8'($urandom);
      cmd_out_ready = (i > 200) ? ($urandom % 3 != 0) : ($urandom % 5 == 0);
      #1;
      check("R14 ready", cmd_in_ready, cq.size() < CDEPTH);
      check("R14 valid", cmd_out_valid, cq.size() > 0);
      if (cmd_out_valid && cq.size() > 0) check("R14 data", cmd_out_data, cq[0]);
      if (cmd_out_valid && cmd_out_ready && cq.size() > 0) void'(cq.pop_front());
      if (cmd_in_valid && cmd_in_ready) cq.push_back(cmd_in_data);
      @(negedge clk);
    end
    cmd_in_valid = 1'b0; cmd_out_ready = 1'b0;

    // R11 chip reset
    cmd_in_valid = 1'b1; cmd_in_data = 8'h77; @(negedge clk); cmd_in_valid = 1'b0;
    wr(4'd4, 8'h05);
    check("R11 target set", sel_target, 3'd5);
    wr(4'd2, 8'h99);
    wr(4'd8, 8'h40);
    wr(4'd3, 8'h02);
    rd(4'd8, v); check("R11 cfg1", v, 8'h07);
    rd(4'd7, v); check("R11 flags", v, exp_flags(0));
    rd(4'd14, v); check("R11 id back", v, ID);
    rd(4'd4, v); check("R11 status", v, 8'h00);
    check("R11 cmd fifo empty", cmd_out_valid, 0);
    check("R11 target", sel_target, 3'd0);
    check("R11 irq", irq_o, 0);

    report();
  end
endmodule